// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block controls a successive-approximation analog-to-digital converter that has many input channels. Software writes one 8-bit control register to choose three things: how many conversions run (4 or 8), whether the controller converts one channel repeatedly or a group of consecutive channels, and whether it stops after one pass or keeps scanning. The controller then works through the sequence with the converter. For each conversion it drives a channel number and a start strobe, and it waits for the converter's done pulse. It stores each returned data word in a numbered result slot.

When a full pass has completed, a flag in the control register goes high. In continuous mode, scanning keeps going and the flag stays high. Writing the register at any time does four things: it drops the flag, it throws away the conversion in flight, it drops any done pulse still pending from that conversion, and it starts a new sequence at conversion 0. The converter itself is outside the block. It only has to answer the most recent start strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Reading `reg_rdata` returns the register at all times. Bit 7 is the completion flag, bit 6 picks 8 conversions (1) or 4 (0), bit 5 turns on continuous scanning, bit 4 turns on multi-channel mode, and bits 3..0 hold the channel select value.
- R2: A write loads bits 6..0 from `reg_wdata` and forces the flag to 0 in the next cycle, whatever value is written to bit 7.
- R3: The flag goes to 1 on the same clock edge that accepts the last conversion of a pass. That is the 4th conversion when bit 6 is 0 and the 8th when bit 6 is 1.
- R4: In continuous mode the sequence restarts at conversion 0 after each pass, and the flag stays at 1 until the next register write.
- R5: In the cycle after a write, `conv_start` pulses for conversion 0. A done pulse that arrives in the same cycle as the write is dropped, as is one still pending from the aborted conversion, and neither writes a result slot.
- R6: When continuous mode is off, no further `conv_start` is issued after the last conversion of the pass until the next write.
- R7: When multi-channel mode is off, every conversion uses channel bits 3..0.
- R8: In 4-conversion multi-channel mode, conversion k (k = 0..3) uses channel {bit3, bit2, k[1:0]}. Bits 1..0 are ignored.
- R9: In 8-conversion multi-channel mode, conversion k (k = 0..7) uses channel {bit3, k[2:0]}. Bits 2..0 are ignored.
- R10: Conversion k is stored in result slot k, and `res_sel` = k reads that slot back. A 4-conversion pass leaves slots 4..7 unchanged.
- R11: After reset the register reads 0, all result slots read 0, and no `conv_start` is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| res_sel | input | 3 | Result slot to read |
| res_rdata | output | RW | Contents of the selected result slot |
| conv_chan | output | 4 | Channel for the current conversion |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| conv_done | input | 1 | Converter finished the latest started conversion |
| conv_data | input | RW | Converter result, valid while `conv_done` is high |

## Verification
The assertions assume that the converter raises `conv_done` only for the conversion it was most recently started on. They also assume that a new start strobe cancels any earlier conversion, so a stale done can arrive only in the cycle of a write or in the cycle of the start that follows it. The converter model in the bench restarts its latency counter on every strobe and has a single done output. Random latencies and random control words therefore stay inside these assumptions. Directed writes placed on the exact cycle of a done pulse, and on the cycle just before one, exercise the abort path at its edges.

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [2:0]    res_sel,
  output logic [RW-1:0] res_rdata,
  output logic [3:0]    conv_chan,
  output logic          conv_start,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_data
);
  localparam int NSLOT = 8;
  localparam int IW = $clog2(NSLOT);

  logic [6:0]    ctrl;
  logic          flag, active, waiting;
  logic [IW-1:0] idx;
  logic [RW-1:0] res [NSLOT];

  wire          cnt8  = ctrl[6];
  wire          scan  = ctrl[5];
  wire          multi = ctrl[4];
  wire [IW-1:0] last  = cnt8 ? IW'(NSLOT - 1) : IW'(NSLOT / 2 - 1);
  wire          accept = waiting & conv_done & ~reg_wr;

  assign reg_rdata  = {flag, ctrl};
  assign res_rdata  = res[res_sel];
  assign conv_start = active & ~waiting;

  always_comb begin
    if (!multi)    conv_chan = ctrl[3:0];
    else if (cnt8) conv_chan = {ctrl[3], idx};
    else           conv_chan = {ctrl[3:2], idx[1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      flag    <= 1'b0;
      active  <= 1'b0;
      waiting <= 1'b0;
      idx     <= '0;
    end else if (reg_wr) begin
      ctrl    <= reg_wdata[6:0];
      flag    <= 1'b0;
      active  <= 1'b1;
      waiting <= 1'b0;
      idx     <= '0;
    end else begin
      if (conv_start) waiting <= 1'b1;
      if (accept) begin
        waiting <= 1'b0;
        if (idx == last) begin
          flag <= 1'b1;
          idx  <= '0;
          if (!scan) active <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                        res[i] <= '0;
      else if (accept && idx == IW'(i))  res[i] <= conv_data;
    end
  end

  AST_WR_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_rdata[7]); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !reg_wr) |=> reg_rdata[7]); // R4
  AST_WR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> conv_start); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !reg_wr) |=> !conv_start); // R5
  AST_IDLE_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] && !reg_rdata[5] && !reg_wr) |-> !conv_start); // R6
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !$past(reg_wr)) |-> $stable(conv_chan)); // R7
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int RW = 10;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [2:0] res_sel = 0;
  logic [RW-1:0] res_rdata, conv_data;
  logic [3:0] conv_chan;
  logic conv_start, conv_done;

  adc_seq_ctrl #(.RW(RW)) u0 (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int cnt = 0, lat = 3, nst = 0;
  logic [RW-1:0] dq = 0, rnd;
  logic [3:0] lchan [64];
  logic [RW-1:0] ldat [64];
  logic [RW-1:0] old [8];

  assign conv_done = (cnt == 1);
  assign conv_data = dq;

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (conv_start) begin
      cnt <= lat;
      rnd = RW'($urandom);
      dq <= rnd;
      if (nst < 64) begin lchan[nst] = conv_chan; ldat[nst] = rnd; end
      nst = nst + 1;
    end else if (cnt != 0) cnt <= cnt - 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_chan(input logic [7:0] c, input int k);
    if (!c[4]) return c[3:0];
    if (c[6]) return {c[3], 3'(k)};
    return {c[3:2], 2'(k)};
  endfunction

  task automatic rd_slot(input int i, output logic [RW-1:0] v);
    res_sel = 3'(i); #1; v = res_rdata;
  endtask

  task automatic snap();
    for (int i = 0; i < 8; i++) rd_slot(i, old[i]);
  endtask

  task automatic wait_flag(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      seen = reg_rdata[7];
    end
  endtask

  task automatic check_pass(input logic [7:0] c, input string tag);
    int n = c[6] ? 8 : 4;
    logic [RW-1:0] v;
    for (int k = 0; k < n; k++) begin
      chk(lchan[k] == exp_chan(c, k), c[4] ? (c[6] ? "R9 chan8" : "R8 chan4") : "R7 single", lchan[k], exp_chan(c, k));
      rd_slot(k, v);
      chk(v == ldat[k], {"R10 slot ", tag}, v, ldat[k]);
    end
    for (int k = n; k < 8; k++) begin
      rd_slot(k, v);
      chk(v == old[k], "R10 untouched slot", v, old[k]);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    nst = 0; reg_wr = 1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    chk(reg_rdata == {1'b0, v[6:0]}, "R1 R2 readback", reg_rdata, {1'b0, v[6:0]});
    chk(conv_start == 1'b1, "R5 start after write", conv_start, 1);
  endtask

  task automatic single_run(input logic [7:0] c);
    bit seen; int n0;
    snap();
    wr(c);
    wait_flag(seen);
    chk(seen, "R3 flag set", seen, 1);
    chk(nst == (c[6] ? 8 : 4), "R3 flag after last", nst, c[6] ? 8 : 4);
    check_pass(c, "single");
    n0 = nst;
    repeat (30) @(negedge clk);
    chk(nst == n0, "R6 idle after pass", nst, n0);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    logic [7:0] c;
    bit seen;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(reg_rdata == 8'h00, "R11 reg reset", reg_rdata, 0);
    chk(conv_start == 1'b0, "R11 no start", conv_start, 0);
    for (int i = 0; i < 8; i++) begin
      rd_slot(i, v);
      chk(v == '0, "R11 slot reset", v, 0);
    end

    single_run(8'h9F);
    single_run(8'h57);
    single_run(8'h1B);
    single_run(8'h5C);
    single_run(8'h06);

    for (int t = 0; t < 25; t++) begin
      c = 8'($urandom) & 8'hDF;
      lat = 1 + int'($urandom % 5);
      single_run(c);
    end

    lat = 2;
    wr(8'h70);
    for (int i = 0; i < 3000 && nst < 24; i++) begin
      @(negedge clk);
      if (nst > 8) chk(reg_rdata[7] == 1'b1, "R4 flag sticky", reg_rdata[7], 1);
    end
    for (int k = 0; k < 24; k++)
      chk(lchan[k] == exp_chan(8'h70, k % 8), "R4 R9 scan order", lchan[k], exp_chan(8'h70, k % 8));
    wr(8'h40);
    chk(reg_rdata[7] == 1'b0, "R4 write clears scan flag", reg_rdata[7], 0);
    wait_flag(seen);

    for (int m = 1; m <= 2; m++) begin
      lat = 20;
      snap();
      @(negedge clk);
      reg_wr = 1; reg_wdata = 8'h52; nst = 0;
      @(negedge clk);
      reg_wr = 0;
      while (cnt != m) @(negedge clk);
      lat = 3; nst = 0;
      reg_wr = 1; reg_wdata = 8'h1A;
      @(negedge clk);
      reg_wr = 0;
      @(negedge clk);
      rd_slot(0, v);
      chk(v == old[0], m == 1 ? "R5 same-cycle done dropped" : "R5 pending done dropped", v, old[0]);
      wait_flag(seen);
      chk(seen, "R5 restarted pass done", seen, 1);
      chk(nst == 4, "R5 restart count", nst, 4);
      check_pass(8'h1A, "restart");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule